// File: doc/BRIEF.md
# Piecewise-Quadratic Mantissa Square Root

This block takes the fraction field F of a normalised floating-point significand together with one bit saying whether the unbiased exponent is odd. It returns the fraction field of the square root's significand. For an even exponent the operand is Z = 1.F. For an odd exponent the operand is Z = 2 x 1.F. In both cases Z lies in [1, 4), the root lies in [1, 2), and the output is its fractional part rounded faithfully. Faithful means the output is one of the two representable values on either side of the exact root. The exponent of the result and special operands (zero, infinity, NaN, subnormals) are handled elsewhere.

The range is covered by 2^K short sub-intervals, each with its own quadratic. Half of them span [1, 2) and half span [2, 4), so the intervals for even exponents are half as wide as those for odd exponents. A table built at elaboration time holds three fixed-point coefficients per interval. The table is indexed by the parity bit concatenated with the K-1 leading fraction bits. The remaining fraction bits form an offset into the interval. They are placed one bit position apart for the two parities, so a single Horner datapath serves both parities. The half-unit rounding term is already added into each constant coefficient, so the last step simply keeps the top WF bits. The pipeline accepts one operand per cycle.

Top module: `sqrt_poly_top`

## Requirements
- R1: A result appears on `out_valid`/`out_frac` exactly 5 clock cycles after the edge that samples `in_valid` high. `out_valid` is high in that cycle and in no other.
- R2: With `in_odd`=0, `out_frac` is floor or ceiling of sqrt(1 + F/2^WF) * 2^WF minus 2^WF. Here F is `in_frac` read as an unsigned integer.
- R3: With `in_odd`=1, the operand is 2 x (1 + F/2^WF), and `out_frac` is one of the two neighbouring WF-bit fractions of its root.
- R4: When the root rounds up to 2.0, `out_frac` saturates to all ones. One such input is `in_odd`=1 with `in_frac` all ones.
- R5: When the operand has an exactly representable root, that root is returned exactly. Examples: F=0 even gives 0; 1.5625 gives 0x4000; 2.25 gives 0x8000; 3.0625 gives 0xC000.
- R6: Operands presented on consecutive cycles are each computed independently, with no interference between neighbours.
- R7: A cycle with `in_valid` low produces a cycle with `out_valid` low 5 cycles later, and it does not disturb results already in flight.
- R8: While `rst_n` is low, and afterwards until the first result arrives, `out_valid` is 0.
- R9: Operands whose fraction bits below the table index are all zeros or all ones are still rounded faithfully. These operands sit at the edges of a sub-interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_frac | input | WF | Fraction bits F of the significand 1.F |
| in_odd | input | 1 | 1 when the exponent is odd (operand doubled) |
| out_valid | output | 1 | Result present this cycle |
| out_frac | output | WF | Fraction bits of the root in [1, 2) |

## Verification
Random fractions with both parities show that every one of the 128 polynomials meets the faithful bound. Fractions forced to the start and end of a sub-interval show whether the offset alignment is off by one bit for either parity. Operands with exact roots tell faithful output apart from correct output, because only one answer is acceptable for them. The all-ones odd operand exercises saturation. An unbroken stream, and a stream with random gaps, separate per-stage enable faults from datapath faults.

// File: rtl/sqrt_poly_pkg.sv
package sqrt_poly_pkg;

  // Fractional bits of the operand while the table is generated (Z in [1,4)).
  localparam int ZF = 60;
  // Fractional bits of the sampled root values.
  localparam int RF = 30;

  // Bitwise integer square root, floor, for arguments below 2^62.
  function automatic logic [63:0] isqrt_u64(input logic [63:0] n);
    logic [63:0] root;
    logic [63:0] trial;
    root = '0;
    for (int b = 31; b >= 0; b--) begin
      trial = root | (64'd1 << b);
      if (trial * trial <= n) root = trial;
    end
    return root;
  endfunction

  // One coefficient of interval 'addr': sel 0 = constant (with the half-ulp
  // rounding term), 1 = linear, 2 = quadratic. The quadratic interpolates the
  // root at both ends and at the middle of the interval.
  function automatic longint coef_calc(input int sel, input int addr, input int wf,
                                       input int k, input int c0f, input int c1f,
                                       input int c2f);
    int          odd;
    int          idx;
    int          hb;
    logic [63:0] z0;
    logic [63:0] hw;
    longint      f0;
    longint      fm;
    longint      f1;
    longint      one;
    longint      res;
    one = 1;
    odd = (addr >> (k - 1)) & 1;
    idx = addr & ((1 << (k - 1)) - 1);
    hb  = (odd != 0) ? k - 2 : k - 1;
    hw  = 64'd1 << (ZF - hb);
    z0  = ((odd != 0) ? 64'd2 : 64'd1) << ZF;
    z0  = z0 + (64'(idx) << (ZF - hb));
    f0  = longint'(isqrt_u64(z0));
    fm  = longint'(isqrt_u64(z0 + (hw >> 1)));
    f1  = longint'(isqrt_u64(z0 + hw));
    case (sel)
      0:       res = ((f0 + (one <<< (RF - 1 - c0f))) >>> (RF - c0f)) + (one <<< (c0f - wf - 1));
      1:       res = (4 * fm - 3 * f0 - f1) >>> (RF - hb - c1f);
      default: res = (2 * (f0 - 2 * fm + f1)) >>> (RF - 2 * hb - c2f);
    endcase
    return res;
  endfunction

endpackage

// File: rtl/sqrt_arg_align.sv
module sqrt_arg_align #(
  parameter int WF = 16,
  parameter int K  = 7,
  localparam int AW = K,
  localparam int UW = WF - K + 2
) (
  input  logic [WF-1:0] frac_i,
  input  logic          odd_i,
  output logic [AW-1:0] addr_o,
  output logic [UW-1:0] arg_o
);

  logic [WF-K:0] low;

  always_comb begin
    low    = frac_i[WF-K:0];
    addr_o = {odd_i, frac_i[WF-1 -: K-1]};
    // Odd operands are doubled: the offset moves up one bit position.
    if (odd_i) arg_o = {low, 1'b0};
    else       arg_o = {1'b0, low};
  end

endmodule

// File: rtl/sqrt_coef_rom.sv
module sqrt_coef_rom #(
  parameter int WF  = 16,
  parameter int K   = 7,
  parameter int C0F = 22,
  parameter int C1F = 20,
  parameter int C2F = 16,
  localparam int DEPTH = 2 ** K,
  localparam int C0W   = C0F + 2,
  localparam int C1W   = C1F,
  localparam int C2W   = C2F + 1
) (
  input  logic                  clk,
  input  logic                  en_i,
  input  logic [K-1:0]          addr_i,
  output logic [C0W-1:0]        c0_o,
  output logic [C1W-1:0]        c1_o,
  output logic signed [C2W-1:0] c2_o
);

  logic [C0W-1:0]        tab_c0 [DEPTH];
  logic [C1W-1:0]        tab_c1 [DEPTH];
  logic signed [C2W-1:0] tab_c2 [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam longint V0 = sqrt_poly_pkg::coef_calc(0, g, WF, K, C0F, C1F, C2F);
    localparam longint V1 = sqrt_poly_pkg::coef_calc(1, g, WF, K, C0F, C1F, C2F);
    localparam longint V2 = sqrt_poly_pkg::coef_calc(2, g, WF, K, C0F, C1F, C2F);
    assign tab_c0[g] = C0W'(V0);
    assign tab_c1[g] = C1W'(V1);
    assign tab_c2[g] = C2W'(V2);
  end

  logic [C0W-1:0]        c0_d;
  logic [C1W-1:0]        c1_d;
  logic signed [C2W-1:0] c2_d;

  always_comb begin
    c0_d = tab_c0[addr_i];
    c1_d = tab_c1[addr_i];
    c2_d = tab_c2[addr_i];
  end

  always_ff @(posedge clk) begin
    if (en_i) begin
      c0_o <= c0_d;
      c1_o <= c1_d;
      c2_o <= c2_d;
    end
  end

endmodule

// File: rtl/sqrt_horner.sv
module sqrt_horner #(
  parameter int WF  = 16,
  parameter int K   = 7,
  parameter int C0F = 22,
  parameter int C1F = 20,
  parameter int C2F = 16,
  localparam int UW  = WF - K + 2,
  localparam int C0W = C0F + 2,
  localparam int C1W = C1F,
  localparam int C2W = C2F + 1,
  localparam int S1W = C1F + 2,
  localparam int RW  = C0F + 3,
  localparam int PW1 = C2W + UW + 1,
  localparam int PW2 = S1W + UW + 1,
  localparam int SH1 = C2F + WF - C1F,
  localparam int SH2 = C1F + WF - C0F
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  valid_i,
  input  logic [UW-1:0]         arg_i,
  input  logic [C0W-1:0]        c0_i,
  input  logic [C1W-1:0]        c1_i,
  input  logic signed [C2W-1:0] c2_i,
  output logic                  valid_o,
  output logic [WF-1:0]         frac_o
);

  // Valid chain: stage 1 multiply, stage 2 add, stage 3 multiply, stage 4 add.
  logic v1, v2, v3;

  // Stage 1 registers
  logic signed [S1W-1:0] t1_q;
  logic [C1W-1:0]        c1_q1;
  logic [C0W-1:0]        c0_q1;
  logic [UW-1:0]         u_q1;
  // Stage 2 registers
  logic signed [S1W-1:0] s1_q;
  logic [C0W-1:0]        c0_q2;
  logic [UW-1:0]         u_q2;
  // Stage 3 registers
  logic signed [RW-1:0]  t2_q;
  logic [C0W-1:0]        c0_q3;

  logic signed [PW1-1:0] prod1;
  logic signed [S1W-1:0] t1_d;
  logic signed [S1W-1:0] s1_d;
  logic signed [PW2-1:0] prod2;
  logic signed [RW-1:0]  t2_d;
  logic signed [RW-1:0]  r_d;
  logic [WF-1:0]         frac_d;

  always_comb begin
    prod1  = c2_i * $signed({1'b0, arg_i});
    t1_d   = S1W'(prod1 >>> SH1);
    s1_d   = $signed({2'b00, c1_q1}) + t1_q;
    prod2  = s1_q * $signed({1'b0, u_q2});
    t2_d   = RW'(prod2 >>> SH2);
    r_d    = $signed({1'b0, c0_q3}) + t2_q;
    if (r_d[C0F+1]) frac_d = '1;
    else            frac_d = WF'(r_d >> (C0F - WF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1      <= 1'b0;
      v2      <= 1'b0;
      v3      <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      v1      <= valid_i;
      v2      <= v1;
      v3      <= v2;
      valid_o <= v3;
    end
  end

  always_ff @(posedge clk) begin
    if (valid_i) begin
      t1_q  <= t1_d;
      c1_q1 <= c1_i;
      c0_q1 <= c0_i;
      u_q1  <= arg_i;
    end
    if (v1) begin
      s1_q  <= s1_d;
      c0_q2 <= c0_q1;
      u_q2  <= u_q1;
    end
    if (v2) begin
      t2_q  <= t2_d;
      c0_q3 <= c0_q2;
    end
    if (v3) begin
      frac_o <= frac_d;
    end
  end

  // R2: every interval of the root function curves downwards.
  p_curv_neg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |-> c2_i[C2W-1]);

  // R3: the inner Horner sum (the slope) stays positive for both parities.
  p_slope_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |-> (!s1_q[S1W-1] && (s1_q != '0)));

  // R4: the pre-truncation root stays within [1, 3).
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    v3 |-> (r_d[RW-1:C0F] == 3'd1 || r_d[RW-1:C0F] == 3'd2));

endmodule

// File: rtl/sqrt_poly_top.sv
module sqrt_poly_top #(
  parameter int WF  = 16,
  parameter int K   = 7,
  parameter int G   = 6,
  parameter int C1F = 20,
  parameter int C2F = 16,
  localparam int C0F = WF + G,
  localparam int UW  = WF - K + 2,
  localparam int C0W = C0F + 2,
  localparam int C1W = C1F,
  localparam int C2W = C2F + 1,
  localparam int LAT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [WF-1:0] in_frac,
  input  logic          in_odd,
  output logic          out_valid,
  output logic [WF-1:0] out_frac
);

  logic [K-1:0]          addr;
  logic [UW-1:0]         arg;
  logic [UW-1:0]         arg_q;
  logic                  v0;
  logic [C0W-1:0]        c0;
  logic [C1W-1:0]        c1;
  logic signed [C2W-1:0] c2;

  sqrt_arg_align #(.WF(WF), .K(K)) u_align (
    .frac_i (in_frac),
    .odd_i  (in_odd),
    .addr_o (addr),
    .arg_o  (arg)
  );

  sqrt_coef_rom #(.WF(WF), .K(K), .C0F(C0F), .C1F(C1F), .C2F(C2F)) u_rom (
    .clk    (clk),
    .en_i   (in_valid),
    .addr_i (addr),
    .c0_o   (c0),
    .c1_o   (c1),
    .c2_o   (c2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v0 <= 1'b0;
    else        v0 <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) arg_q <= arg;
  end

  sqrt_horner #(.WF(WF), .K(K), .C0F(C0F), .C1F(C1F), .C2F(C2F)) u_eval (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (v0),
    .arg_i   (arg_q),
    .c0_i    (c0),
    .c1_i    (c1),
    .c2_i    (c2),
    .valid_o (out_valid),
    .frac_o  (out_frac)
  );

  // Checker support: cycles since reset release, saturating at LAT.
  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst < LAT) since_rst <= since_rst + 3'd1;
  end

  // R1 and R7: output valid mirrors the input valid delayed by LAT cycles.
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == LAT) |-> (out_valid == $past(in_valid, LAT)));

  // R8: nothing emerges before an operand could have travelled the pipe.
  p_quiet_after_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < LAT) |-> !out_valid);

endmodule

// File: tb/tb_sqrt_poly_top.sv
module tb_sqrt_poly_top;

  localparam int CLK_PERIOD = 10;
  localparam int WF         = 16;
  localparam int LAT        = 5;
  localparam int WATCHDOG   = 100000;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [WF-1:0] in_frac;
  logic          in_odd;
  logic          out_valid;
  logic [WF-1:0] out_frac;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  logic          hv [8];
  logic [WF-1:0] hf [8];
  logic          ho [8];
  string         ht [8];

  sqrt_poly_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_frac   (in_frac),
    .in_odd    (in_odd),
    .out_valid (out_valid),
    .out_frac  (out_frac)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Newton iteration integer root (floor).
  function automatic longint nroot(input longint n);
    longint x;
    longint y;
    x = n;
    y = (x + 1) / 2;
    while (y < x) begin
      x = y;
      y = (x + n / x) / 2;
    end
    return x;
  endfunction

  // Faithful acceptance: floor or ceiling of the exact root, ceiling clamped.
  function automatic bit accept(input logic [WF-1:0] f, input logic odd,
                                input logic [WF-1:0] got, output logic [WF-1:0] lo);
    longint n;
    longint s;
    bit     exact;
    n     = (longint'(f) + 65536) << (odd ? 17 : 16);
    s     = nroot(n);
    exact = (s * s == n);
    lo    = WF'(s - 65536);
    return (got == lo) || (!exact && lo != '1 && got == lo + 1'b1);
  endfunction

  task automatic check_out();
    logic          ev;
    logic [WF-1:0] lo;
    int            idx;
    string         tg;
    idx = (cyc - LAT) & 7;
    if (cyc < LAT) begin
      ev = 1'b0;
      tg = "R8";
    end else begin
      ev = hv[idx];
      tg = ev ? "R1" : "R7";
    end
    checks++;
    if (out_valid !== ev) begin
      errors++;
      $display("FAIL %s out_valid actual %b expected %b (cycle %0d)", tg, out_valid, ev, cyc);
    end else if (ev) begin
      checks++;
      if (!accept(hf[idx], ho[idx], out_frac, lo)) begin
        errors++;
        $display("FAIL %s frac=%h odd=%b actual %h expected %h (or next)",
                 ht[idx], hf[idx], ho[idx], out_frac, lo);
      end
    end
  endtask

  task automatic step(input logic v, input logic [WF-1:0] f, input logic o, input string tg);
    check_out();
    in_valid    = v;
    in_frac     = f;
    in_odd      = o;
    hv[cyc & 7] = v;
    hf[cyc & 7] = f;
    ho[cyc & 7] = o;
    ht[cyc & 7] = tg;
    cyc++;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    logic [31:0] r;
    logic [WF-1:0] f;
    void'($urandom(32'd20240611));
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_frac  = '0;
    in_odd   = 1'b0;
    // R8: quiet during reset
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R8 out_valid in reset actual %b expected 0", out_valid);
      end
    end
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b0, '0, 1'b0, "R8");
    // R5: exact roots
    step(1'b1, 16'h0000, 1'b0, "R5");
    step(1'b1, 16'h4000, 1'b0, "R5");
    step(1'b1, 16'h9000, 1'b0, "R5");
    step(1'b1, 16'h2000, 1'b1, "R5");
    step(1'b1, 16'h8800, 1'b1, "R5");
    // R4: saturation
    step(1'b1, 16'hFFFF, 1'b1, "R4");
    // R2 / R3 fixed corners
    step(1'b1, 16'hFFFF, 1'b0, "R2");
    step(1'b1, 16'h0000, 1'b1, "R3");
    step(1'b1, 16'h8000, 1'b1, "R3");
    step(1'b0, '0, 1'b0, "R7");
    // R9: sub-interval edges for both parities
    step(1'b1, 16'h03FF, 1'b0, "R9");
    step(1'b1, 16'h0400, 1'b0, "R9");
    step(1'b1, 16'h03FF, 1'b1, "R9");
    step(1'b1, 16'h0400, 1'b1, "R9");
    for (int i = 0; i < 200; i++) begin
      r = $urandom;
      f = WF'($urandom);
      f[9:0] = r[1] ? 10'h3FF : 10'h000;
      step(1'b1, f, r[0], "R9");
    end
    // R6: unbroken stream
    for (int i = 0; i < 300; i++) begin
      r = $urandom;
      step(1'b1, WF'($urandom), r[0], "R6");
    end
    // R2 / R3 / R7: random operands with random gaps
    for (int i = 0; i < 2500; i++) begin
      r = $urandom;
      if (r[3:2] == 2'b00) step(1'b0, WF'($urandom), r[0], "R7");
      else                 step(1'b1, WF'($urandom), r[0], r[0] ? "R3" : "R2");
    end
    repeat (8) step(1'b0, '0, 1'b0, "R7");
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
    $finish;
  end

endmodule